// File: doc/BRIEF.md
# I2C Target Register-Access Front End

This block is the serial host port of a sensing chip. A host reaches a 64-entry register space over a two-wire I2C bus (SCL/SDA). The block decodes START, repeated START and STOP, responds only to its own 7-bit target address, and takes the first byte of a write as the register address. Later bytes of a write go to the register port. A read returns the register the pointer selects. With bursts, the pointer advances after every byte and wraps from 63 to 0. Bit 6 of the register-address byte freezes the pointer, so a host can poll one location without sending the address again.

Two consecutive addresses hold a 16-bit measurement that the block keeps internally. The sampler delivers it through an update strobe. Reading the low byte captures the matching high byte in a shadow latch, and updates that arrive mid-pair are held back. The two bytes a host sees therefore always come from one sample. All other addresses go to an external register file through a simple address, write-strobe and read-data port. SCL and SDA are sampled by a system clock that runs at least eight times the bit rate. SDA is driven open-drain through an output enable.

Top module: `i2c_regport`

## Requirements
- R1: After reset the block releases SDA (sda_oe = 0), the register pointer is 0 and auto-increment is enabled.
- R2: The block ACKs only an address byte whose upper seven bits equal DEV_ADDR (default 0x5A). After any other address it never pulls SDA low and performs no register write until the next START.
- R3: In a write, bits 5..0 of the first byte after the address load the pointer. Each following byte is ACKed and produces one reg_we pulse with reg_addr equal to the pointer and reg_wdata equal to the byte.
- R4: With bit 6 of the register-address byte clear, the pointer advances by one after every data byte, written or read, and wraps from 63 to 0.
- R5: With bit 6 set, the pointer stays fixed for every data byte. The flag persists across repeated STARTs and is captured again from every new register-address byte.
- R6: A write holding only the register-address byte, followed by a repeated START and a read, returns the register at that pointer, then successive registers while the host ACKs.
- R7: When the host NACKs a read byte, the block releases SDA and drives nothing more until a START or STOP.
- R8: Address MEAS_LO (default 0x22) returns the low byte of the measurement and MEAS_LO+1 returns the high byte. Reading the low byte latches the high byte of the same sample. A measurement update that arrives after a low-byte read is held until the high byte is read or a STOP occurs, and is then applied.
- R9: Writes to the two measurement addresses are ACKed but cause no reg_we and do not change the measurement.
- R10: SDA output enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_addr | output | 6 | Register pointer, used for reads and writes |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_we |
| reg_rdata | input | 8 | Read data for reg_addr, combinational |
| meas_upd | input | 1 | One-cycle strobe: new measurement sample |
| meas_in | input | 16 | Measurement sample, valid with meas_upd |

## Verification
The hardest case to reach is a measurement update that lands between the low-byte and high-byte reads. In a plain burst, the high byte is loaded for transmit during the host ACK of the low byte, so there is almost no gap in which to insert an update. The bench therefore reads the low byte, ends that read with a NACK and no STOP, and fires an update while the pair is still open. It then uses repeated STARTs to repoint to the high address and read it. The expected old high byte there, followed by the new sample on a fresh read, shows both the hold and its later release.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h5A,
  parameter logic [5:0] MEAS_LO  = 6'h22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [5:0]  reg_addr,
  output logic        reg_we,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata,
  input  logic        meas_upd,
  input  logic [15:0] meas_in
);
  localparam logic [5:0] MEAS_HI = MEAS_LO + 6'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKD, S_REG, S_ACKR, S_WR, S_ACKW, S_RD, S_ACKH, S_IGN
  } st_t;
  st_t st;

  logic [1:0] scl_sy, sda_sy;
  logic scl_p, sda_p;
  logic [7:0] sh, tx, shadow;
  logic [3:0] cnt;
  logic rw, noinc, hack, pend_v, pair_busy;
  logic [5:0] ptr;
  logic [15:0] meas_q, pend_q;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire bus_start = scl_s & scl_p & sda_p & ~sda_s;
  wire bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  wire [5:0] ptr_nxt = noinc ? ptr : ptr + 6'd1;
  wire       is_meas = (ptr == MEAS_LO) || (ptr == MEAS_HI);
  wire [7:0] rd_byte = (ptr == MEAS_LO) ? meas_q[7:0] :
                       (ptr == MEAS_HI) ? (pair_busy ? shadow : meas_q[15:8]) :
                       reg_rdata;
  wire load_rd = scl_fall & (((st == S_ACKD) & rw) | ((st == S_ACKH) & hack));

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sda_oe    <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      noinc     <= 1'b0;
      hack      <= 1'b0;
      ptr       <= '0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (bus_stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (st == S_DEV || st == S_REG || st == S_WR) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (st == S_RD)   cnt  <= cnt + 4'd1;
        if (st == S_ACKH) hack <= ~sda_s;
      end else if (scl_fall) begin
        unique case (st)
          S_DEV: if (cnt == 4'd8) begin
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              st     <= S_ACKD;
            end else begin
              st <= S_IGN;
            end
          end
          S_ACKD: begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr_nxt;
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_REG;
            end
          end
          S_REG: if (cnt == 4'd8) begin
            ptr    <= sh[5:0];
            noinc  <= sh[6];
            sda_oe <= 1'b1;
            st     <= S_ACKR;
          end
          S_ACKR: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WR;
          end
          S_WR: if (cnt == 4'd8) begin
            reg_we    <= ~is_meas;
            reg_wdata <= sh;
            sda_oe    <= 1'b1;
            st        <= S_ACKW;
          end
          S_ACKW: begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            ptr    <= ptr_nxt;
            st     <= S_WR;
          end
          S_RD: begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_ACKH;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
            end
          end
          S_ACKH: begin
            if (hack) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              ptr    <= ptr_nxt;
              cnt    <= '0;
              st     <= S_RD;
            end else begin
              st <= S_IGN;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q    <= '0;
      pend_q    <= '0;
      pend_v    <= 1'b0;
      pair_busy <= 1'b0;
      shadow    <= '0;
    end else begin
      if (load_rd && ptr == MEAS_LO) begin
        pair_busy <= 1'b1;
        shadow    <= meas_q[15:8];
      end else if ((load_rd && ptr == MEAS_HI) || bus_stop) begin
        pair_busy <= 1'b0;
      end
      if (meas_upd && !pair_busy) begin
        meas_q <= meas_in;
        pend_v <= 1'b0;
      end else if (meas_upd) begin
        pend_q <= meas_in;
        pend_v <= 1'b1;
      end else if (pend_v && !pair_busy) begin
        meas_q <= pend_q;
        pend_v <= 1'b0;
      end
    end
  end

  assert_ign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe);

  assert_ptr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACKW && scl_fall && noinc) |=> $stable(ptr));

  assert_pair_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_busy |=> $stable(meas_q));

  assert_no_meas_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr != MEAS_LO && reg_addr != MEAS_HI));

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p) |-> $stable(sda_oe));

endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb_top;
  localparam int T = 10;
  localparam logic [6:0] DEV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic meas_upd = 1'b0;
  logic [15:0] meas_in = '0;
  logic sda_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  int checks = 0, errors = 0, we_cnt = 0, oe_viol = 0, cyc = 0;
  logic prev_oe = 1'b0;

  wire sda_line = sda_h & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .meas_upd(meas_upd), .meas_in(meas_in)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rst_n && scl_h && sda_oe !== prev_oe) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (T) @(negedge clk);
  endtask

  task automatic b_start();
    sda_h = 1'b1; hw(); scl_h = 1'b1; hw(); sda_h = 1'b0; hw(); scl_h = 1'b0; hw();
  endtask

  task automatic b_stop();
    sda_h = 1'b0; hw(); scl_h = 1'b1; hw(); sda_h = 1'b1; hw();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hw(); scl_h = 1'b1; hw(); scl_h = 1'b0; hw();
    end
    sda_h = 1'b1; hw(); scl_h = 1'b1; hw(); ack = ~sda_line; scl_h = 1'b0; hw();
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl_h = 1'b1; hw(); b[i] = sda_line; scl_h = 1'b0;
    end
    hw(); sda_h = ~give_ack; hw(); scl_h = 1'b1; hw(); scl_h = 1'b0; hw(); sda_h = 1'b1;
  endtask

  task automatic pulse_meas(input logic [15:0] v);
    @(negedge clk); meas_in = v; meas_upd = 1'b1;
    @(negedge clk); meas_upd = 1'b0;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    check(reg_addr == 6'd0, "R1 pointer zero", reg_addr, 0);
  endtask

  task automatic t_foreign();
    bit a; int w0 = we_cnt;
    b_start(); wbyte({7'h2C, 1'b0}, a);
    check(!a, "R2 foreign address not acked", a, 0);
    wbyte(8'h10, a); check(!a, "R2 later byte not acked", a, 0);
    wbyte(8'h99, a); b_stop();
    check(we_cnt == w0, "R2 no write after foreign address", we_cnt, w0);
  endtask

  task automatic t_burst_write();
    bit a; int w0 = we_cnt;
    b_start(); wbyte({DEV, 1'b0}, a);
    check(a, "R2 own address acked", a, 1);
    wbyte(8'h05, a); check(a, "R3 register byte acked", a, 1);
    wbyte(8'hA1, a); check(a, "R3 data acked", a, 1);
    wbyte(8'hA2, a); wbyte(8'hA3, a); b_stop();
    check(we_cnt == w0 + 3, "R3 one strobe per byte", we_cnt, w0 + 3);
    check(mem[5] == 8'hA1, "R3 first write", mem[5], 8'hA1);
    check(mem[6] == 8'hA2 && mem[7] == 8'hA3, "R4 increment write", {mem[6], mem[7]}, 16'hA2A3);
  endtask

  task automatic t_wrap();
    bit a;
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h3E, a);
    wbyte(8'h62, a); wbyte(8'h63, a); wbyte(8'h60, a); b_stop();
    check(mem[62] == 8'h62 && mem[63] == 8'h63, "R4 top addresses", {mem[62], mem[63]}, 16'h6263);
    check(mem[0] == 8'h60, "R4 wrap to 0", mem[0], 8'h60);
  endtask

  task automatic t_noinc_write();
    bit a; logic [7:0] keep = mem[17];
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h50, a);
    wbyte(8'h11, a); wbyte(8'h22, a); b_stop();
    check(mem[16] == 8'h22, "R5 frozen pointer last byte wins", mem[16], 8'h22);
    check(mem[17] == keep, "R5 neighbour untouched", mem[17], keep);
  endtask

  task automatic t_read_after_ptr();
    bit a; logic [7:0] d0, d1, d2;
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h05, a);
    b_start(); wbyte({DEV, 1'b1}, a);
    check(a, "R6 read address acked", a, 1);
    rbyte(1'b1, d0); rbyte(1'b1, d1); rbyte(1'b0, d2); b_stop();
    check(d0 == 8'hA1, "R6 read at pointer", d0, 8'hA1);
    check(d1 == 8'hA2 && d2 == 8'hA3, "R5 flag recaptured, R4 read increment",
          {d1, d2}, 16'hA2A3);
  endtask

  task automatic t_poll_read();
    bit a; logic [7:0] d0, d1, d2;
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h45, a);
    b_start(); wbyte({DEV, 1'b1}, a);
    rbyte(1'b1, d0); rbyte(1'b1, d1);
    b_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, d2); b_stop();
    check(d0 == 8'hA1 && d1 == 8'hA1, "R5 polled read", {d0, d1}, 16'hA1A1);
    check(d2 == 8'hA1, "R5 flag kept across repeated START", d2, 8'hA1);
  endtask

  task automatic t_nack();
    bit a; logic [7:0] d0, d1; int w0 = we_cnt;
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h06, a);
    b_start(); wbyte({DEV, 1'b1}, a);
    rbyte(1'b0, d0);
    check(d0 == 8'hA2, "R7 byte before NACK", d0, 8'hA2);
    rbyte(1'b0, d1);
    check(d1 == 8'hFF, "R7 bus released after NACK", d1, 8'hFF);
    wbyte(8'h00, a);
    check(!a, "R7 no ack after NACK", a, 0);
    b_stop();
    check(we_cnt == w0, "R7 no write after NACK", we_cnt, w0);
  endtask

  task automatic t_meas_pair();
    bit a; logic [7:0] lo, hi, lo2, hi2;
    pulse_meas(16'h1234);
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h22, a);
    b_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, lo);
    pulse_meas(16'hABCD);
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h23, a);
    b_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b0, hi); b_stop();
    check(lo == 8'h34, "R8 low byte", lo, 8'h34);
    check(hi == 8'h12, "R8 high byte from same sample", hi, 8'h12);
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h22, a);
    b_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b1, lo2); rbyte(1'b0, hi2); b_stop();
    check({hi2, lo2} == 16'hABCD, "R8 held update applied", {hi2, lo2}, 16'hABCD);
  endtask

  task automatic t_meas_write();
    bit a, a1; logic [7:0] lo, hi; int w0 = we_cnt;
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h22, a);
    wbyte(8'h55, a1); wbyte(8'h66, a); wbyte(8'h77, a); b_stop();
    check(a1, "R9 measurement write acked", a1, 1);
    check(we_cnt == w0 + 1, "R9 only non-measurement byte written", we_cnt, w0 + 1);
    check(mem[36] == 8'h77, "R9 increment past pair", mem[36], 8'h77);
    b_start(); wbyte({DEV, 1'b0}, a); wbyte(8'h22, a);
    b_start(); wbyte({DEV, 1'b1}, a); rbyte(1'b1, lo); rbyte(1'b0, hi); b_stop();
    check({hi, lo} == 16'hABCD, "R9 measurement unchanged", {hi, lo}, 16'hABCD);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 3 + 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_foreign();
    t_burst_write();
    t_wrap();
    t_noinc_write();
    t_read_after_ptr();
    t_poll_read();
    t_nack();
    t_meas_pair();
    t_meas_write();
    check(oe_viol == 0, "R10 SDA stable while SCL high", oe_viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule